// File: doc/BRIEF.md
# Binary-GCD Modular Divider

This block computes the modular quotient q = y · x⁻¹ mod M for an odd modulus M. It uses only shifts, additions and subtractions, following the binary extended-Euclid method. Two working pairs are kept. The divisor pair (a, u) starts at (x, y) and the modulus pair (b, v) starts at (M, 0). The invariants a·q ≡ u and b·q ≡ v (mod M) hold at every step.

Each cycle performs exactly one step:

- When a is even, the step removes one or two trailing zero bits from a. It halves or quarters u modulo M, first adding 0 to 3 multiples of M so that u becomes divisible.
- When a is odd, the smaller of a and b is subtracted from the larger. The companions are subtracted modulo M, and the pairs swap when a was the smaller.

When a reaches zero, b holds gcd(x, M) and v holds the quotient.

A caller pulses `start` with x, y and M presented, and waits for the one-cycle `done` pulse. `quot` and `err` then stay valid until the next accepted start. Operands must satisfy x < M, y < M, and M must be odd. If x shares a factor with M, including x = 0, the block still finishes and raises `err`.

Top module: `gcd_mod_div`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `quot` is 0.
- R2: For odd M, x < M and y < M with gcd(x, M) = 1, the block returns `quot` < M with quot·x ≡ y (mod M) and `err` = 0.
- R3: `done` is high for exactly one cycle per operation. `quot` and `err` hold their values after that until the next accepted start.
- R4: When gcd(x, M) ≠ 1 (including x = 0 with M > 1), the block still asserts `done`, and `err` is 1.
- R5: A `start` pulse seen while `busy` is 1 is ignored: the running operation finishes with the result of its own operands.
- R6: `done` rises no later than 4·W+2 clock edges after the edge that accepts `start`.
- R7: `busy` is 1 from the edge that accepts `start` until the edge that raises `done`, where it drops to 0.
- R8: Corner operands give exact values: y = 0 gives `quot` = 0, x = 1 gives `quot` = y, and M = 1 with x = y = 0 gives `quot` = 0 with `err` = 0.
- R9: During a run, the working modulus value b stays odd and both companion values stay below M.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| op_x | input | W | Divisor x, must be below M |
| op_y | input | W | Dividend y, must be below M |
| modulus | input | W | Odd modulus M |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| err | output | 1 | x was not invertible modulo M |
| quot | output | W | Quotient y·x⁻¹ mod M |

## Verification
The assertions check on every cycle the properties that need no knowledge of the arithmetic answer:

- b remains odd and the companions stay reduced below M during a run.
- `done` is a single-cycle pulse that follows a busy period.
- The step counter never passes the 4·W bound.
- A start seen while busy leaves the latched modulus unchanged.

Only the bench scenarios can show that the returned quotient really satisfies quot·x ≡ y. The same applies to the error flag, which must track the gcd. The bench covers table vectors, pseudo-random odd moduli, the x = 0, y = 0, x = 1 and M = 1 corners, result holding after `done`, and an overlapping start.

// File: rtl/gcd_div_pkg.sv
// Shared types for the binary-GCD modular divider.
package gcd_div_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gcd_state_e;
endpackage

// File: rtl/gcd_mod_sub.sv
// Modular subtractor: diff = (minu - subt) mod M.
// Assumes minu < M and subt < M, so one conditional add of M suffices.
module gcd_mod_sub #(
    parameter int W = 16
) (
    input  logic [W-1:0] minu,
    input  logic [W-1:0] subt,
    input  logic [W-1:0] modv,
    output logic [W-1:0] diff
);
    logic [W:0] raw;
    logic [W:0] fixed;

    // Subtract, then wrap back by M when the difference went negative.
    always_comb begin
        raw   = {1'b0, minu} - {1'b0, subt};
        fixed = raw + {1'b0, modv};
        diff  = raw[W] ? fixed[W-1:0] : raw[W-1:0];
    end
endmodule

// File: rtl/gcd_mod_shift.sv
// Modular halving/quartering: res = val / 2 or val / 4 modulo an odd M.
// Adds k*M (k in 0..3) so the sum becomes divisible, then shifts.
// Assumes val < M and M odd; the result is then below M.
module gcd_mod_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] modv,
    input  logic         quad,
    output logic [W-1:0] res
);
    localparam int SW = W + 2;

    logic [1:0]    prod_lo;
    logic [1:0]    k;
    logic [SW-1:0] m_ext;
    logic [SW-1:0] kmul;
    logic [SW-1:0] sum;

    // Choose the multiple of M that clears the low one or two bits.
    // For odd M, M*M = 1 mod 4, so k = -val*M mod 4 clears two bits.
    always_comb begin
        prod_lo = val[1:0] * modv[1:0];
        k       = quad ? (2'd0 - prod_lo) : {1'b0, val[0]};
        m_ext   = {2'b00, modv};
        case (k)
            2'd0:    kmul = '0;
            2'd1:    kmul = m_ext;
            2'd2:    kmul = m_ext << 1;
            default: kmul = m_ext + (m_ext << 1);
        endcase
        sum = {2'b00, val} + kmul;
        res = quad ? sum[W+1:2] : sum[W:1];
    end
endmodule

// File: rtl/gcd_mod_div.sv
// Sequential modular divider: quot = y * x^-1 mod M, one step per cycle.
// Assumes M odd, x < M, y < M. Pairs (a,u) and (b,v) keep a*q = u and
// b*q = v (mod M); the run ends when a reaches zero, leaving gcd in b.
module gcd_mod_div
    import gcd_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic [W-1:0] modulus,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic [W-1:0] quot
);
    localparam int LIMIT = 4 * W;
    localparam int CW    = $clog2(LIMIT + 2) + 1;

    gcd_state_e    state_q;
    logic [W-1:0]  a_q, b_q, u_q, v_q, m_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  quot_q;
    logic          done_q, err_q;

    logic [W:0]    ab_diff;
    logic [W-1:0]  ba_diff;
    logic          swap;
    logic          a_quad;
    logic [W-1:0]  sub_minu, sub_subt, uv_diff, u_shift;

    // Magnitude compare through the borrow of a - b; sets the swap flag.
    always_comb begin
        ab_diff  = {1'b0, a_q} - {1'b0, b_q};
        ba_diff  = b_q - a_q;
        swap     = ab_diff[W];
        a_quad   = (a_q[1:0] == 2'b00);
        sub_minu = swap ? v_q : u_q;
        sub_subt = swap ? u_q : v_q;
    end

    gcd_mod_sub #(.W(W)) u_sub (
        .minu (sub_minu),
        .subt (sub_subt),
        .modv (m_q),
        .diff (uv_diff)
    );

    gcd_mod_shift #(.W(W)) u_shift_unit (
        .val  (u_q),
        .modv (m_q),
        .quad (a_quad),
        .res  (u_shift)
    );

    // Control FSM and working registers: load, step, and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            a_q     <= '0;
            b_q     <= '0;
            u_q     <= '0;
            v_q     <= '0;
            m_q     <= '0;
            cnt_q   <= '0;
            quot_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        a_q     <= op_x;
                        b_q     <= modulus;
                        u_q     <= op_y;
                        v_q     <= '0;
                        m_q     <= modulus;
                        cnt_q   <= '0;
                        state_q <= ST_RUN;
                    end
                end
                default: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (a_q == '0) begin
                        quot_q  <= v_q;
                        err_q   <= (b_q != {{(W-1){1'b0}}, 1'b1});
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (!a_q[0]) begin
                        a_q <= a_quad ? (a_q >> 2) : (a_q >> 1);
                        u_q <= u_shift;
                    end else if (swap) begin
                        a_q <= ba_diff;
                        b_q <= a_q;
                        u_q <= uv_diff;
                        v_q <= u_q;
                    end else begin
                        a_q <= ab_diff[W-1:0];
                        u_q <= uv_diff;
                    end
                end
            endcase
        end
    end

    assign busy = (state_q == ST_RUN);
    assign done = done_q;
    assign err  = err_q;
    assign quot = quot_q;

    // R9: the modulus-side value stays odd for the whole run.
    a_r9_b_odd: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> b_q[0]);

    // R9: companion values stay reduced below M.
    a_r9_companions_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (u_q < m_q) && (v_q < m_q));

    // R3: done lasts a single cycle.
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done only rises right after a busy cycle.
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R6: the step count never exceeds the 4*W bound.
    a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= CW'(LIMIT)));

    // R5: a start while busy leaves the latched modulus alone.
    a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(m_q));
endmodule

// File: tb/tb_gcd_mod_div.sv
module tb_gcd_mod_div;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_x = '0, op_y = '0, modulus = '0;
    logic         busy, done, err;
    logic [W-1:0] quot;

    int checks = 0;
    int errors = 0;
    bit timed_out = 0;

    always #2 clk = ~clk;

    gcd_mod_div #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_x(op_x), .op_y(op_y), .modulus(modulus),
        .busy(busy), .done(done), .err(err), .quot(quot)
    );

    // x, y, M
    localparam logic [47:0] VEC [10] = '{
        {16'd3,     16'd5,     16'd7},
        {16'd1,     16'd1234,  16'd65521},
        {16'd2,     16'd1,     16'd65521},
        {16'd40000, 16'd12345, 16'd65521},
        {16'd65520, 16'd1,     16'd65521},
        {16'd10,    16'd3,     16'd11},
        {16'd2,     16'd7,     16'd65535},
        {16'd32768, 16'd100,   16'd65535},
        {16'd1023,  16'd999,   16'd1025},
        {16'd6,     16'd5,     16'd9}
    };

    function automatic longint gcd_f(longint p, longint q);
        longint t;
        while (q != 0) begin
            t = p % q; p = q; q = t;
        end
        return p;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Launch one operation and wait for done; lat counts edges after acceptance.
    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y,
                          input logic [W-1:0] m, output int lat);
        @(negedge clk);
        op_x = x; op_y = y; modulus = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", busy, 1);
        lat = 0;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        if (!done) begin
            timed_out = 1;
            chk(1'b0, "R6 done never seen", lat, 4*W+2);
        end
    endtask

    // Check quot/err against gcd and the congruence.
    task automatic check_result(input logic [W-1:0] x, input logic [W-1:0] y,
                                input logic [W-1:0] m, input int lat);
        longint g;
        g = gcd_f(longint'(x), longint'(m));
        if (x == 0) g = m;
        if (g == 1) begin
            chk(err == 1'b0, "R2 err low", err, 0);
            chk(quot < m && ((longint'(quot) * x) % m) == y,
                "R2 quot*x mod M", (longint'(quot) * x) % m, y);
        end else begin
            chk(err == 1'b1, "R4 err on non-invertible", err, 1);
        end
        chk(lat <= 4*W+2, "R6 latency", lat, 4*W+2);
        chk(busy == 1'b0, "R7 busy low at done", busy, 0);
    endtask

    initial begin
        int lat;
        logic [31:0] lfsr;
        logic [W-1:0] rm, rx, ry;
        fork
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_none

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(err == 0,  "R1 err", err, 0);
        chk(quot == 0, "R1 quot", quot, 0);
        rst_n = 1'b1;

        // R2/R4: vector table
        for (int i = 0; i < 10; i++) begin
            run_op(VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], lat);
            check_result(VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], lat);
        end

        // R2: pseudo-random odd moduli
        lfsr = 32'hACE1_2357;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rm = lfsr[15:0] | 16'd1;
            if (rm < 3) rm = 16'd3;
            rx = W'((longint'(lfsr[31:16]) * 7 + 1) % rm);
            ry = W'(longint'(lfsr[23:8]) % rm);
            run_op(rx, ry, rm, lat);
            check_result(rx, ry, rm, lat);
        end

        // R3: result held, done low afterwards
        run_op(16'd3, 16'd5, 16'd7, lat);
        chk(quot == 16'd4, "R3 quot at done", quot, 4);
        repeat (5) @(negedge clk);
        chk(done == 0, "R3 done single pulse", done, 0);
        chk(quot == 16'd4, "R3 quot held", quot, 4);

        // R4: x = 0
        run_op(16'd0, 16'd9, 16'd101, lat);
        chk(err == 1, "R4 x zero err", err, 1);

        // R8: corners
        run_op(16'd1234, 16'd0, 16'd65521, lat);
        chk(quot == 0 && err == 0, "R8 y zero", quot, 0);
        run_op(16'd1, 16'd777, 16'd65521, lat);
        chk(quot == 16'd777, "R8 x one", quot, 777);
        run_op(16'd0, 16'd0, 16'd1, lat);
        chk(quot == 0 && err == 0, "R8 M one", {err, quot}, 0);

        // R5: overlapping start ignored
        @(negedge clk);
        op_x = 16'd40000; op_y = 16'd12345; modulus = 16'd65521; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op_x = 16'd3; op_y = 16'd5; modulus = 16'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        chk(((longint'(quot) * 40000) % 65521) == 12345 && quot < 16'd65521,
            "R5 first operands win", (longint'(quot) * 40000) % 65521, 12345);
        @(negedge clk);
        chk(busy == 0, "R5 no second run", busy, 0);

        if (timed_out) chk(1'b0, "watchdog", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog exit path if the main sequence hangs.
    initial begin
        wait (timed_out);
        repeat (2) @(negedge clk);
        if (checks < 1000000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule